// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver

This block receives a write-only serial stream for a display controller. While the active-low select line is held low, each rising edge of an external serial clock samples one bit of the data line. The bits are packed most significant first into a byte. The eighth edge delivers the byte on a parallel output, together with a flag that tells display data from a command. A strobe one system clock wide marks each delivered byte.

All four serial inputs come from outside the system clock domain. Each passes through its own synchronizer chain of equal length, so the inputs stay aligned with one another. Clock edges are then detected in the system domain. Raising the select line clears the bit count and the partial byte at once. The next selected transfer therefore always starts on a byte boundary.

Top module: `serial_byte_rx`

## Requirements
- R1: During and right after reset, byte_valid is 0, byte_out is 0x00 and is_data is 0.
- R2: Bits are packed most significant first: the first sampled bit lands in byte_out bit 7 and the eighth in bit 0.
- R3: Each completed byte raises byte_valid for exactly one system clock, and byte_valid stays low between bytes.
- R4: is_data takes the level that rs had at the eighth sampling edge: 1 means display data, 0 means a command.
- R5: While cs_n is high, serial clock edges have no effect, and no byte_valid is produced.
- R6: If cs_n rises before the eighth edge, the partial byte is discarded with no byte_valid. The next selected transfer starts again at bit 7.
- R7: Several bytes sent within one select period are each delivered in order, with no gap needed between them.
- R8: byte_out and is_data hold their values between byte_valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdata | input | 1 | Serial data, most significant bit first |
| rs | input | 1 | Register select: 1 for display data, 0 for command |
| byte_out | output | 8 | Last received byte |
| is_data | output | 1 | Classification of the last received byte |
| byte_valid | output | 1 | One-clock strobe for a new byte |

## Verification
A bit counter that is off by one shows up at once as a byte shifted by one position. It can also show up as a strobe that comes one serial clock early or late. This is visible on the first byte after reset, or on the first byte after an aborted transfer. A counter that is not cleared on deselect corrupts the very next byte after a partial transfer. If register select is captured at the wrong time, the flag on a byte shows the wrong class when rs changes during that byte. All of these faults reach the ports within a few system clocks after the eighth serial edge.

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              rs,
  output logic [BYTE_W-1:0] byte_out,
  output logic              is_data,
  output logic              byte_valid
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] cs_sy, ck_sy, sd_sy, rs_sy;
  logic cs_s, ck_s, sd_s, rs_s, ck_d, rise;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] next_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy <= '1;
      ck_sy <= '0;
      sd_sy <= '0;
      rs_sy <= '0;
      ck_d  <= 1'b0;
    end else begin
      cs_sy <= {cs_sy[SYNC_STAGES-2:0], cs_n};
      ck_sy <= {ck_sy[SYNC_STAGES-2:0], sclk};
      sd_sy <= {sd_sy[SYNC_STAGES-2:0], sdata};
      rs_sy <= {rs_sy[SYNC_STAGES-2:0], rs};
      ck_d  <= ck_s;
    end
  end

  assign cs_s    = cs_sy[SYNC_STAGES-1];
  assign ck_s    = ck_sy[SYNC_STAGES-1];
  assign sd_s    = sd_sy[SYNC_STAGES-1];
  assign rs_s    = rs_sy[SYNC_STAGES-1];
  assign rise    = ck_s & ~ck_d & ~cs_s;
  assign next_sh = {shreg[BYTE_W-2:0], sd_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      shreg      <= '0;
      byte_out   <= '0;
      is_data    <= 1'b0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (cs_s) begin
        cnt   <= '0;
        shreg <= '0;
      end else if (rise) begin
        shreg <= next_sh;
        if (cnt == LAST) begin
          cnt        <= '0;
          byte_out   <= next_sh;
          is_data    <= rs_s;
          byte_valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

module serial_byte_rx_chk #(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              rs_s,
  input logic [CNT_W-1:0]  cnt,
  input logic [BYTE_W-1:0] byte_out,
  input logic              is_data,
  input logic              byte_valid
);
  p_one_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |-> ($stable(byte_out) && $stable(is_data)));
  p_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> !$past(cs_s));
  p_eighth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> ($past(cnt) == CNT_W'(BYTE_W - 1)));
  p_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> (is_data == $past(rs_s)));
endmodule

bind serial_byte_rx serial_byte_rx_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rs_s(rs_s), .cnt(cnt),
  .byte_out(byte_out), .is_data(is_data), .byte_valid(byte_valid)
);

// File: tb/test_serial_byte_rx.sv
module test_serial_byte_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdata = 1'b0, rs = 1'b0;
  logic [7:0] byte_out;
  logic is_data, byte_valid;
  int checks = 0, failures = 0;
  int pulses = 0, wide = 0;
  logic [7:0] last_b = '0;
  logic last_rs = 1'b0, prev_v = 1'b0;

  always #10 clk = ~clk;

  serial_byte_rx i_serial_byte_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdata(sdata), .rs(rs),
    .byte_out(byte_out), .is_data(is_data), .byte_valid(byte_valid)
  );

  localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h1C3, 9'h080, 9'h101, 9'h0FF, 9'h100};

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid) begin
        pulses++;
        last_b  = byte_out;
        last_rs = is_data;
        if (prev_v) wide++;
      end
      prev_v = byte_valid;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input logic r, input int n);
    for (int i = 0; i < n; i++) begin
      sdata = b[7-i];
      rs    = r;
      tick(4);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
    end
    tick(6);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p0;
    tick(3);
    check("R1 valid", byte_valid, 0);
    check("R1 byte", byte_out, 0);
    check("R1 flag", is_data, 0);
    rst_n = 1'b1;
    tick(3);
    check("R1 after release", byte_valid, 0);

    for (int k = 0; k < 6; k++) begin
      p0 = pulses;
      cs_n = 1'b0;
      tick(4);
      send_bits(VEC[k][7:0], VEC[k][8], 8);
      cs_n = 1'b1;
      tick(4);
      check("R2 byte", last_b, VEC[k][7:0]);
      check("R4 flag", last_rs, VEC[k][8]);
      check("R3 one pulse", pulses - p0, 1);
      check("R8 hold byte", byte_out, VEC[k][7:0]);
    end

    p0 = pulses;
    send_bits(8'h3C, 1'b1, 16);
    check("R5 deselected", pulses - p0, 0);
    check("R5 output kept", byte_out, 8'h00);

    p0 = pulses;
    cs_n = 1'b0; tick(4);
    send_bits(8'hE0, 1'b0, 5);
    cs_n = 1'b1; tick(6);
    check("R6 no valid on abort", pulses - p0, 0);
    cs_n = 1'b0; tick(4);
    send_bits(8'h5A, 1'b1, 8);
    cs_n = 1'b1; tick(4);
    check("R6 realigned", last_b, 8'h5A);
    check("R6 one pulse", pulses - p0, 1);

    p0 = pulses;
    cs_n = 1'b0; tick(4);
    send_bits(8'h12, 1'b0, 8);
    check("R7 first", last_b, 8'h12);
    check("R7 first flag", last_rs, 0);
    send_bits(8'h34, 1'b1, 8);
    check("R7 second", last_b, 8'h34);
    check("R7 second flag", last_rs, 1);
    cs_n = 1'b1; tick(4);
    check("R7 two pulses", pulses - p0, 2);

    cs_n = 1'b0; tick(4);
    for (int i = 0; i < 8; i++) begin
      sdata = 1'b1;
      rs = (i == 7);
      tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
    end
    tick(6);
    cs_n = 1'b1; tick(4);
    check("R4 rs at eighth edge", last_rs, 1);
    check("R2 all ones", last_b, 8'hFF);

    check("R3 never wide", wide, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule